// File: doc/BRIEF.md
# 8-bit Arithmetic-Logic Unit with Carry and Digit-Carry Flags

This block is the combinational datapath core of a small accumulator machine. One operand comes from the working register (`a_i`). The other comes from a file register or an immediate literal (`b_i`). A 4-bit code selects one of eleven operations: add, subtract, AND, OR, XOR, complement, increment, decrement, nibble swap, and rotate through carry in either direction. Within the same cycle the block returns the 8-bit result and the zero, digit-carry and carry flags.

Different operations update different flags. For that reason the block also drives a 3-bit write-enable mask, and the surrounding status register uses it to decide which flag bits to load. Subtraction is carried out as addition of the two's complement of the working register. As a result, carry and digit carry read as inverted borrows. A rotate moves the incoming carry into the vacated bit and sends the bit shifted out into carry.

Top module: `alu8_core`

## Requirements
- R1: Op code 0 (add) gives res_o = (b_i + a_i) mod 256, with mask 3'b111. c_o is 1 when the sum overflows bit 7. dc_o is 1 when b_i[3:0] + a_i[3:0] exceeds 15.
- R2: Op code 1 (subtract) gives res_o = (b_i - a_i) mod 256, with mask 3'b111. c_o is 1 when b_i >= a_i, meaning no borrow. dc_o is 1 when b_i[3:0] >= a_i[3:0]. 8'h00 - 8'h00 yields c_o = 1 and z_o = 1.
- R3: Whenever mask bit 2 is set, z_o is 1 exactly when res_o is 8'h00.
- R4: Op codes 2, 3 and 4 give a_i AND b_i, a_i OR b_i and a_i XOR b_i respectively, with mask 3'b100.
- R5: Op codes 5, 6 and 7 give ~b_i, b_i + 1 and b_i - 1 respectively, wrapping modulo 256, with mask 3'b100.
- R6: Op code 8 gives {b_i[3:0], b_i[7:4]}, with mask 3'b000.
- R7: Op code 9 (rotate left) gives {b_i[6:0], c_i}, with c_o = b_i[7] and mask 3'b001.
- R8: Op code 10 (rotate right) gives {c_i, b_i[7:1]}, with c_o = b_i[0] and mask 3'b001.
- R9: The mask bits map as [2] = zero, [1] = digit carry, [0] = carry. Any flag output whose mask bit is 0 is driven to 0.
- R10: Op codes 11 to 15 are reserved and give res_o = 8'h00 with mask 3'b000.
- R11: c_i has no effect on any output except under op codes 9 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | 8 | Working-register operand |
| b_i | input | 8 | File-register or literal operand |
| c_i | input | 1 | Current carry flag, used by rotates |
| res_o | output | 8 | Result |
| z_o | output | 1 | Zero flag |
| dc_o | output | 1 | Digit carry, inverted digit borrow on subtract |
| c_o | output | 1 | Carry, inverted borrow on subtract, shifted-out bit on rotate |
| flag_we_o | output | 3 | Flag write enables: [2] zero, [1] digit carry, [0] carry |

## Verification
The block holds no state, so any internal fault appears at the ports in the same cycle the operands are applied.

- A wrong nibble split or a wrong carry chain shows up as a bad `dc_o` or `c_o` on operands that sit at the 15/16 or 255/256 boundaries.
- A wrong operand order on subtract flips `c_o` whenever `a_i` differs from `b_i`.
- A mis-decoded operation gives the wrong result, or a wrong mask, on the very next vector that uses that code.

The directed corners and the broad sweep each compare every output on every vector.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_IOR = 4'd3,
    OP_XOR = 4'd4,
    OP_COM = 4'd5,
    OP_INC = 4'd6,
    OP_DEC = 4'd7,
    OP_SWP = 4'd8,
    OP_RLC = 4'd9,
    OP_RRC = 4'd10
  } alu_op_e;

  // mask bit positions, decoded by the status register
  localparam int unsigned FLG_C  = 0;
  localparam int unsigned FLG_DC = 1;
  localparam int unsigned FLG_Z  = 2;
  localparam int unsigned FLG_N  = 3;

  typedef logic [FLG_N-1:0] flag_mask_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int unsigned W     = 8,
  parameter int unsigned SPLIT = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         dc_o
);
  localparam int unsigned HW = W - SPLIT;

  logic [W-1:0]  y;
  logic [SPLIT:0] lo;
  logic [HW:0]    hi;

  // subtract = b + ~a + 1, carries become inverted borrows
  assign y  = sub_i ? ~a_i : a_i;
  assign lo = {1'b0, b_i[SPLIT-1:0]} + {1'b0, y[SPLIT-1:0]} + {{SPLIT{1'b0}}, sub_i};
  assign hi = {1'b0, b_i[W-1:SPLIT]} + {1'b0, y[W-1:SPLIT]} + {{HW{1'b0}}, lo[SPLIT]};

  assign sum_o = {hi[HW-1:0], lo[SPLIT-1:0]};
  assign c_o   = hi[HW];
  assign dc_o  = lo[SPLIT];
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  localparam int unsigned H = W / 2;

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_IOR:  res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_COM:  res_o = ~b_i;
      OP_INC:  res_o = b_i + W'(1);
      OP_DEC:  res_o = b_i - W'(1);
      OP_SWP:  res_o = {b_i[H-1:0], b_i[W-1:H]};
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu8_rot.sv
module alu8_rot #(
  parameter int unsigned W = 8
) (
  input  logic         left_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] res_o,
  output logic         c_o
);
  always_comb begin
    if (left_i) begin
      res_o = {b_i[W-2:0], c_i};
      c_o   = b_i[W-1];
    end else begin
      res_o = {c_i, b_i[W-1:1]};
      c_o   = b_i[0];
    end
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] res_i,
  input  logic         c_raw_i,
  input  logic         dc_raw_i,
  output flag_mask_t   we_o,
  output logic         z_o,
  output logic         dc_o,
  output logic         c_o
);
  always_comb begin
    we_o = '0;
    unique case (op_i)
      OP_ADD, OP_SUB:                 we_o = 3'b111;
      OP_AND, OP_IOR, OP_XOR,
      OP_COM, OP_INC, OP_DEC:         we_o = 3'b100;
      OP_RLC, OP_RRC:                 we_o = 3'b001;
      default:                        we_o = '0;
    endcase
  end

  // unaffected flags are held low
  assign z_o  = we_o[FLG_Z]  & ~(|res_i);
  assign dc_o = we_o[FLG_DC] & dc_raw_i;
  assign c_o  = we_o[FLG_C]  & c_raw_i;
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned SPLIT = W / 2
) (
  input  logic [3:0]       op_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic             c_i,
  output logic [W-1:0]     res_o,
  output logic             z_o,
  output logic             dc_o,
  output logic             c_o,
  output logic [FLG_N-1:0] flag_we_o
);
  alu_op_e    op;
  logic [W-1:0] sum, lres, rres;
  logic       sum_c, sum_dc, rot_c;
  logic       is_arith, is_rot;
  logic       c_raw;
  flag_mask_t we;

  assign op       = alu_op_e'(op_i);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB);
  assign is_rot   = (op == OP_RLC) || (op == OP_RRC);

  alu8_addsub #(.W(W), .SPLIT(SPLIT)) u_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (op == OP_SUB),
    .sum_o (sum),
    .c_o   (sum_c),
    .dc_o  (sum_dc)
  );

  alu8_logic #(.W(W)) u_logic (
    .op_i  (op),
    .a_i   (a_i),
    .b_i   (b_i),
    .res_o (lres)
  );

  alu8_rot #(.W(W)) u_rot (
    .left_i (op == OP_RLC),
    .b_i    (b_i),
    .c_i    (c_i),
    .res_o  (rres),
    .c_o    (rot_c)
  );

  always_comb begin
    if (is_arith)    res_o = sum;
    else if (is_rot) res_o = rres;
    else             res_o = lres;
  end

  assign c_raw = is_rot ? rot_c : sum_c;

  alu8_flags #(.W(W)) u_flags (
    .op_i     (op),
    .res_i    (res_o),
    .c_raw_i  (c_raw),
    .dc_raw_i (sum_dc),
    .we_o     (we),
    .z_o      (z_o),
    .dc_o     (dc_o),
    .c_o      (c_o)
  );

  assign flag_we_o = we;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk (
  input logic [3:0] op_i,
  input logic [7:0] a_i,
  input logic [7:0] b_i,
  input logic       c_i,
  input logic [7:0] res_o,
  input logic       z_o,
  input logic       dc_o,
  input logic       c_o,
  input logic [2:0] flag_we_o
);
  always_comb begin
    // R1
    add_sum_chk: assert (op_i != 4'd0 || {c_o, res_o} == ({1'b0, b_i} + {1'b0, a_i}));
    // R2
    sub_borrow_chk: assert (op_i != 4'd1 || c_o == (b_i >= a_i));
    // R3
    zero_flag_chk: assert (!flag_we_o[2] || z_o == (res_o == 8'h00));
    // R6
    swap_no_flag_chk: assert (op_i != 4'd8 || flag_we_o == 3'b000);
    // R7
    rol_carry_chk: assert (op_i != 4'd9 || (c_o == b_i[7] && res_o[0] == c_i));
    // R8
    ror_carry_chk: assert (op_i != 4'd10 || (c_o == b_i[0] && res_o[7] == c_i));
    // R9
    masked_low_chk: assert ((flag_we_o[2] || !z_o) && (flag_we_o[1] || !dc_o) && (flag_we_o[0] || !c_o));
    // R10
    reserved_chk: assert (op_i < 4'd11 || (res_o == 8'h00 && flag_we_o == 3'b000));
  end
endmodule

bind alu8_core alu8_core_chk u_chk (.*);

// File: tb/tb_alu8_core.sv
`timescale 1ns/1ps
module tb_alu8_core;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [3:0] op;
  logic [7:0] a, b, res;
  logic       cin, z, dc, c;
  logic [2:0] we;
  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  alu8_core dut (
    .op_i(op), .a_i(a), .b_i(b), .c_i(cin),
    .res_o(res), .z_o(z), .dc_o(dc), .c_o(c), .flag_we_o(we)
  );

  // returns {res, z, dc, c, mask}
  function automatic logic [13:0] model(input logic [3:0] o, input logic [7:0] x,
                                        input logic [7:0] y, input logic ci);
    logic [7:0] r;
    logic cf, dcf;
    logic [2:0] m;
    int s;
    cf = 1'b0; dcf = 1'b0; r = 8'h00; m = 3'b000;
    case (o)
      4'd0: begin
        s = int'(y) + int'(x); r = s[7:0]; cf = s > 255;
        dcf = (int'(y[3:0]) + int'(x[3:0])) > 15; m = 3'b111;
      end
      4'd1: begin
        s = int'(y) - int'(x); r = s[7:0]; cf = y >= x;
        dcf = y[3:0] >= x[3:0]; m = 3'b111;
      end
      4'd2: begin r = x & y; m = 3'b100; end
      4'd3: begin r = x | y; m = 3'b100; end
      4'd4: begin r = x ^ y; m = 3'b100; end
      4'd5: begin r = ~y;    m = 3'b100; end
      4'd6: begin s = int'(y) + 1; r = s[7:0]; m = 3'b100; end
      4'd7: begin s = int'(y) + 255; r = s[7:0]; m = 3'b100; end
      4'd8: r = {y[3:0], y[7:4]};
      4'd9: begin r = {y[6:0], ci}; cf = y[7]; m = 3'b001; end
      4'd10: begin r = {ci, y[7:1]}; cf = y[0]; m = 3'b001; end
      default: ;
    endcase
    return {r, m[2] & (r == 8'h00), m[1] & dcf, m[0] & cf, m};
  endfunction

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4: return "R4";
      4'd5, 4'd6, 4'd7: return "R5";
      4'd8: return "R6";
      4'd9: return "R7";
      4'd10: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic drive(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y, input logic ci);
    @(posedge clk);
    op = o; a = x; b = y; cin = ci;
    @(negedge clk);
  endtask

  task automatic compare(input string tag, input logic [13:0] exp);
    n_vec++;
    if ({res, z, dc, c, we} !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h c=%b: got res=%h zdcc=%b mask=%b, expected res=%h zdcc=%b mask=%b",
               tag, op, a, b, cin, res, {z, dc, c}, we, exp[13:6], exp[5:3], exp[2:0]);
    end
  endtask

  // explicit expectation: res, {z,dc,c}, mask
  task automatic expect_vec(input string tag, input logic [3:0] o, input logic [7:0] x, input logic [7:0] y,
                            input logic ci, input logic [7:0] er, input logic [2:0] ef, input logic [2:0] em);
    drive(o, x, y, ci);
    compare(tag, {er, ef, em});
  endtask

  task automatic t_idle;
    // all-zero inputs select add: 0+0 -> zero set, carries clear (R1, R3)
    expect_vec("R1", 4'd0, 8'h00, 8'h00, 1'b0, 8'h00, 3'b100, 3'b111);
  endtask

  task automatic t_add;
    expect_vec("R1", 4'd0, 8'h01, 8'h0F, 1'b0, 8'h10, 3'b010, 3'b111);
    expect_vec("R1", 4'd0, 8'h01, 8'hFF, 1'b0, 8'h00, 3'b111, 3'b111);
    expect_vec("R1", 4'd0, 8'h80, 8'h80, 1'b0, 8'h00, 3'b101, 3'b111);
    expect_vec("R3", 4'd0, 8'h12, 8'h34, 1'b0, 8'h46, 3'b000, 3'b111);
  endtask

  task automatic t_sub;
    expect_vec("R2", 4'd1, 8'h00, 8'h00, 1'b0, 8'h00, 3'b111, 3'b111);
    expect_vec("R2", 4'd1, 8'h01, 8'h10, 1'b0, 8'h0F, 3'b001, 3'b111);
    expect_vec("R2", 4'd1, 8'h01, 8'h00, 1'b0, 8'hFF, 3'b000, 3'b111);
    expect_vec("R2", 4'd1, 8'h05, 8'h37, 1'b0, 8'h32, 3'b011, 3'b111);
  endtask

  task automatic t_logic;
    expect_vec("R4", 4'd2, 8'hF0, 8'h0F, 1'b0, 8'h00, 3'b100, 3'b100);
    expect_vec("R4", 4'd3, 8'hA0, 8'h05, 1'b0, 8'hA5, 3'b000, 3'b100);
    expect_vec("R4", 4'd4, 8'h5A, 8'h5A, 1'b0, 8'h00, 3'b100, 3'b100);
  endtask

  task automatic t_unary;
    expect_vec("R5", 4'd5, 8'h00, 8'hFF, 1'b0, 8'h00, 3'b100, 3'b100);
    expect_vec("R5", 4'd6, 8'h00, 8'hFF, 1'b0, 8'h00, 3'b100, 3'b100);
    expect_vec("R5", 4'd7, 8'h00, 8'h00, 1'b0, 8'hFF, 3'b000, 3'b100);
    expect_vec("R5", 4'd7, 8'h00, 8'h01, 1'b0, 8'h00, 3'b100, 3'b100);
  endtask

  task automatic t_swap;
    // zero result still leaves flags low (R6, R9)
    expect_vec("R6", 4'd8, 8'h00, 8'h3C, 1'b1, 8'hC3, 3'b000, 3'b000);
    expect_vec("R9", 4'd8, 8'h00, 8'h00, 1'b0, 8'h00, 3'b000, 3'b000);
  endtask

  task automatic t_rotate;
    expect_vec("R7", 4'd9,  8'h00, 8'h81, 1'b0, 8'h02, 3'b001, 3'b001);
    expect_vec("R7", 4'd9,  8'h00, 8'h00, 1'b1, 8'h01, 3'b000, 3'b001);
    expect_vec("R8", 4'd10, 8'h00, 8'h01, 1'b0, 8'h00, 3'b001, 3'b001);
    expect_vec("R8", 4'd10, 8'h00, 8'h80, 1'b1, 8'hC0, 3'b000, 3'b001);
  endtask

  task automatic t_reserved;
    for (int o = 11; o < 16; o++)
      expect_vec("R10", 4'(o), 8'hFF, 8'hFF, 1'b1, 8'h00, 3'b000, 3'b000);
  endtask

  task automatic t_cin_ignored;
    // R11: c_i set on non-rotate ops must match c_i clear
    for (int o = 0; o < 9; o++) begin
      drive(4'(o), 8'h3A, 8'hC7, 1'b1);
      compare("R11", model(4'(o), 8'h3A, 8'hC7, 1'b0));
    end
  endtask

  task automatic t_sweep;
    for (int o = 0; o < 16; o++)
      for (int x = 0; x < 256; x += 17)
        for (int y = 0; y < 256; y += 5)
          for (int ci = 0; ci < 2; ci++) begin
            drive(4'(o), 8'(x), 8'(y), 1'(ci));
            compare(tag_of(4'(o)), model(4'(o), 8'(x), 8'(y), 1'(ci)));
          end
  endtask

  initial begin
    op = 4'd0; a = 8'h00; b = 8'h00; cin = 1'b0;
    t_idle();
    t_add();
    t_sub();
    t_logic();
    t_unary();
    t_swap();
    t_rotate();
    t_reserved();
    t_cin_ignored();
    t_sweep();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule